// File: doc/BRIEF.md
# Integer Execute Stage with Immediate Forms

This block is the integer execute stage of a 32-bit core. Each cycle it can take one instruction word with a valid strobe. It splits the word into its fields and sends the two source indices to an external register file. It takes the two read values back in the same cycle and computes one of: add, subtract, multiply (low or high half), AND/OR/XOR/NOR, shifts and rotates, or a set-on-compare. Operands come from register/register, register/5-bit-immediate and register/16-bit-immediate encodings.

The block builds the three 16-bit immediate kinds: sign-extended, zero-extended, and moved into the upper half. It enforces the zero-register rules and works out the destination index and write enable. One cycle after an accepted instruction it presents a registered result with a valid flag. The register file consumes that result. Loads, stores, branches and division belong to other units. I-type words with those opcodes pass through without a write and without a fault.

Top module: `int_exec_unit`

## Requirements
- R1: Fields are fixed: bits [5:0] primary opcode, [31:27] source A, [26:22] source B. An I-type word carries a 16-bit immediate in [21:6] and writes register B. The register form has primary opcode 0x3A and carries a 5-bit immediate in [10:6], a secondary opcode in [16:11] and destination C in [21:17]. The read indices equal A and B combinationally.
- R2: Immediates are sign-extended for add-immediate (0x04), multiply-immediate (0x24) and the signed compares (GE 0x08, LT 0x10, NE 0x18, EQ 0x20). They are zero-extended for AND (0x0C), OR (0x14), XOR (0x1C) and the unsigned compares (GEU 0x28, LTU 0x30).
- R3: The upper-half logic forms AND (0x2C), OR (0x34) and XOR (0x3C) use the immediate shifted into bits [31:16], with zeros in bits [15:0].
- R4: The register forms compute add (0x31), sub (0x39), low-half multiply (0x27), AND (0x0E), OR (0x16), XOR (0x1E) and NOR (0x06).
- R5: The register shifts and rotates use only bits [4:0] of operand B: left 0x13, logical right 0x1B, arithmetic right 0x3B, rotate left 0x03, rotate right 0x0B. The immediate shifts use the 5-bit field: left 0x12, logical right 0x1A, arithmetic right 0x3A, rotate left 0x02.
- R6: The compares write 1 when the condition holds and 0 when it does not. Register form codes are EQ 0x20, NE 0x18, GE 0x08, LT 0x10, GEU 0x28, LTU 0x30.
- R7: The high multiplies return bits [63:32] of the 64-bit product: signed×signed 0x1F, unsigned×unsigned 0x07, signed A × unsigned B 0x17.
- R8: A source index of 0 reads as zero, whatever the register file returns.
- R9: A result whose destination is register 0 is not written (write enable low).
- R10: A register-form secondary opcode outside the supported set raises the illegal flag with the result and suppresses the write.
- R11: The output valid follows the input valid by exactly one cycle. With no valid input, the write enable and illegal flag are low. An I-type opcode outside the execute set (for example 0x17) gives no write and no illegal flag.
- R12: While reset is high, and in the first cycle after it, the valid, write-enable and illegal outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction word is valid this cycle |
| in_insn | input | 32 | Instruction word |
| rf_a_idx | output | 5 | Register file read index, port A |
| rf_b_idx | output | 5 | Register file read index, port B |
| rf_a_data | input | 32 | Register file read data, port A |
| rf_b_data | input | 32 | Register file read data, port B |
| out_valid | output | 1 | Registered result is valid |
| out_result | output | 32 | Registered result |
| out_dest | output | 5 | Destination register index |
| out_wen | output | 1 | Write enable for the destination |
| out_illegal | output | 1 | Unsupported secondary opcode |

## Verification
A wrong decode shows on the next cycle, either as the wrong destination index or as a result built from the wrong immediate kind. Sign or zero extension errors show only when the immediate's top bit is set, so the vectors set it. A register 0 that is not forced to zero shows as a polluted sum. A missed shift mask shows only when the upper bits of B are nonzero. Because nothing is stored beyond the output register, every fault appears within one cycle of the instruction that triggers it.

// File: rtl/exu_pkg.sv
package exu_pkg;

  localparam int INSN_W = 32;

  localparam logic [5:0] OPC_REG    = 6'h3A;
  localparam logic [5:0] OPC_ADDI   = 6'h04;
  localparam logic [5:0] OPC_MULI   = 6'h24;
  localparam logic [5:0] OPC_ANDI   = 6'h0C;
  localparam logic [5:0] OPC_ORI    = 6'h14;
  localparam logic [5:0] OPC_XORI   = 6'h1C;
  localparam logic [5:0] OPC_ANDHI  = 6'h2C;
  localparam logic [5:0] OPC_ORHI   = 6'h34;
  localparam logic [5:0] OPC_XORHI  = 6'h3C;
  localparam logic [5:0] OPC_CGEI   = 6'h08;
  localparam logic [5:0] OPC_CLTI   = 6'h10;
  localparam logic [5:0] OPC_CNEI   = 6'h18;
  localparam logic [5:0] OPC_CEQI   = 6'h20;
  localparam logic [5:0] OPC_CGEUI  = 6'h28;
  localparam logic [5:0] OPC_CLTUI  = 6'h30;

  localparam logic [5:0] FX_ADD     = 6'h31;
  localparam logic [5:0] FX_SUB     = 6'h39;
  localparam logic [5:0] FX_MUL     = 6'h27;
  localparam logic [5:0] FX_AND     = 6'h0E;
  localparam logic [5:0] FX_OR      = 6'h16;
  localparam logic [5:0] FX_XOR     = 6'h1E;
  localparam logic [5:0] FX_NOR     = 6'h06;
  localparam logic [5:0] FX_SLL     = 6'h13;
  localparam logic [5:0] FX_SRL     = 6'h1B;
  localparam logic [5:0] FX_SRA     = 6'h3B;
  localparam logic [5:0] FX_ROL     = 6'h03;
  localparam logic [5:0] FX_ROR     = 6'h0B;
  localparam logic [5:0] FX_SLLI    = 6'h12;
  localparam logic [5:0] FX_SRLI    = 6'h1A;
  localparam logic [5:0] FX_SRAI    = 6'h3A;
  localparam logic [5:0] FX_ROLI    = 6'h02;
  localparam logic [5:0] FX_CEQ     = 6'h20;
  localparam logic [5:0] FX_CNE     = 6'h18;
  localparam logic [5:0] FX_CGE     = 6'h08;
  localparam logic [5:0] FX_CLT     = 6'h10;
  localparam logic [5:0] FX_CGEU    = 6'h28;
  localparam logic [5:0] FX_CLTU    = 6'h30;
  localparam logic [5:0] FX_MHSS    = 6'h1F;
  localparam logic [5:0] FX_MHUU    = 6'h07;
  localparam logic [5:0] FX_MHSU    = 6'h17;

  typedef enum logic [4:0] {
    ALU_ADD, ALU_SUB, ALU_MUL, ALU_MHSS, ALU_MHUU, ALU_MHSU,
    ALU_AND, ALU_OR, ALU_XOR, ALU_NOR,
    ALU_SLL, ALU_SRL, ALU_SRA, ALU_ROL, ALU_ROR,
    ALU_CEQ, ALU_CNE, ALU_CGE, ALU_CLT, ALU_CGEU, ALU_CLTU
  } alu_op_e;

  typedef enum logic [1:0] { IMM_SEXT, IMM_ZEXT, IMM_HIGH } imm_kind_e;

  typedef enum logic [1:0] { SRC_REG, SRC_IMM16, SRC_IMM5 } src_b_e;

  typedef enum logic [1:0] { SH_LEFT, SH_RLOG, SH_RARI, SH_RROT } sh_kind_e;

endpackage

// File: rtl/exu_decode.sv
module exu_decode
  import exu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int REG_AW = 5
) (
  input  logic [INSN_W-1:0] insn,
  output logic [REG_AW-1:0] idx_a,
  output logic [REG_AW-1:0] idx_b,
  output logic [REG_AW-1:0] dest,
  output logic              dest_wr,
  output logic              illegal,
  output alu_op_e           op,
  output src_b_e            src_b,
  output logic [DATA_W-1:0] imm_val
);
  localparam int IMM_W = 16;
  localparam int SH5_W = 5;

  logic [5:0]       f_opc;
  logic [5:0]       f_opx;
  logic [IMM_W-1:0] f_imm16;
  logic [SH5_W-1:0] f_imm5;
  logic [REG_AW-1:0] f_c;
  imm_kind_e        kind;

  assign f_opc   = insn[5:0];
  assign f_imm16 = insn[21:6];
  assign f_imm5  = insn[10:6];
  assign f_opx   = insn[16:11];
  assign f_c     = insn[21:17];
  assign idx_a   = insn[31:27];
  assign idx_b   = insn[26:22];

  always_comb begin
    op      = ALU_ADD;
    src_b   = SRC_REG;
    kind    = IMM_SEXT;
    dest    = idx_b;
    dest_wr = 1'b0;
    illegal = 1'b0;
    if (f_opc == OPC_REG) begin
      dest    = f_c;
      dest_wr = 1'b1;
      case (f_opx)
        FX_ADD:  op = ALU_ADD;
        FX_SUB:  op = ALU_SUB;
        FX_MUL:  op = ALU_MUL;
        FX_AND:  op = ALU_AND;
        FX_OR:   op = ALU_OR;
        FX_XOR:  op = ALU_XOR;
        FX_NOR:  op = ALU_NOR;
        FX_SLL:  op = ALU_SLL;
        FX_SRL:  op = ALU_SRL;
        FX_SRA:  op = ALU_SRA;
        FX_ROL:  op = ALU_ROL;
        FX_ROR:  op = ALU_ROR;
        FX_SLLI: begin op = ALU_SLL; src_b = SRC_IMM5; end
        FX_SRLI: begin op = ALU_SRL; src_b = SRC_IMM5; end
        FX_SRAI: begin op = ALU_SRA; src_b = SRC_IMM5; end
        FX_ROLI: begin op = ALU_ROL; src_b = SRC_IMM5; end
        FX_CEQ:  op = ALU_CEQ;
        FX_CNE:  op = ALU_CNE;
        FX_CGE:  op = ALU_CGE;
        FX_CLT:  op = ALU_CLT;
        FX_CGEU: op = ALU_CGEU;
        FX_CLTU: op = ALU_CLTU;
        FX_MHSS: op = ALU_MHSS;
        FX_MHUU: op = ALU_MHUU;
        FX_MHSU: op = ALU_MHSU;
        default: begin
          illegal = 1'b1;
          dest_wr = 1'b0;
        end
      endcase
    end else begin
      src_b   = SRC_IMM16;
      dest_wr = 1'b1;
      case (f_opc)
        OPC_ADDI:  begin op = ALU_ADD;  kind = IMM_SEXT; end
        OPC_MULI:  begin op = ALU_MUL;  kind = IMM_SEXT; end
        OPC_ANDI:  begin op = ALU_AND;  kind = IMM_ZEXT; end
        OPC_ORI:   begin op = ALU_OR;   kind = IMM_ZEXT; end
        OPC_XORI:  begin op = ALU_XOR;  kind = IMM_ZEXT; end
        OPC_ANDHI: begin op = ALU_AND;  kind = IMM_HIGH; end
        OPC_ORHI:  begin op = ALU_OR;   kind = IMM_HIGH; end
        OPC_XORHI: begin op = ALU_XOR;  kind = IMM_HIGH; end
        OPC_CGEI:  begin op = ALU_CGE;  kind = IMM_SEXT; end
        OPC_CLTI:  begin op = ALU_CLT;  kind = IMM_SEXT; end
        OPC_CNEI:  begin op = ALU_CNE;  kind = IMM_SEXT; end
        OPC_CEQI:  begin op = ALU_CEQ;  kind = IMM_SEXT; end
        OPC_CGEUI: begin op = ALU_CGEU; kind = IMM_ZEXT; end
        OPC_CLTUI: begin op = ALU_CLTU; kind = IMM_ZEXT; end
        default:   dest_wr = 1'b0;
      endcase
    end
  end

  always_comb begin
    case (src_b)
      SRC_IMM5: imm_val = DATA_W'(f_imm5);
      default: begin
        case (kind)
          IMM_ZEXT: imm_val = DATA_W'(f_imm16);
          IMM_HIGH: imm_val = DATA_W'({f_imm16, {IMM_W{1'b0}}});
          default:  imm_val = {{(DATA_W-IMM_W){f_imm16[IMM_W-1]}}, f_imm16};
        endcase
      end
    endcase
  end

endmodule

// File: rtl/exu_shifter.sv
module exu_shifter
  import exu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0]         din,
  input  logic [$clog2(DATA_W)-1:0] amt,
  input  sh_kind_e                  kind,
  output logic [DATA_W-1:0]         dout
);
  localparam int SH_W = $clog2(DATA_W);

  logic [DATA_W-1:0] din_rev;
  logic [DATA_W-1:0] rshift;
  logic [DATA_W-1:0] rshift_rev;
  logic [DATA_W-1:0] fun_hi;
  logic [DATA_W-1:0] fun_lo;

  for (genvar i = 0; i < DATA_W; i++) begin : g_rev
    assign din_rev[i]    = din[DATA_W-1-i];
    assign rshift_rev[i] = rshift[DATA_W-1-i];
  end

  always_comb begin
    case (kind)
      SH_LEFT: begin fun_hi = '0; fun_lo = din_rev; end
      SH_RARI: begin fun_hi = {DATA_W{din[DATA_W-1]}}; fun_lo = din; end
      SH_RROT: begin fun_hi = din; fun_lo = din; end
      default: begin fun_hi = '0; fun_lo = din; end
    endcase
    rshift = DATA_W'({fun_hi, fun_lo} >> amt);
  end

  assign dout = (kind == SH_LEFT) ? rshift_rev : rshift;

  logic unused_sh;
  assign unused_sh = ^SH_W;

endmodule

// File: rtl/exu_alu.sv
module exu_alu
  import exu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  alu_op_e           op,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  output logic [DATA_W-1:0] res
);
  localparam int SH_W = $clog2(DATA_W);
  localparam int PW   = 2 * DATA_W;

  logic              a_sgn;
  logic              b_sgn;
  logic [PW-1:0]     ext_a;
  logic [PW-1:0]     ext_b;
  logic [PW-1:0]     prod;
  logic [SH_W-1:0]   sh_amt;
  sh_kind_e          sh_kind;
  logic [DATA_W-1:0] sh_out;
  logic              lt_s;
  logic              lt_u;

  assign a_sgn = (op == ALU_MHSS) || (op == ALU_MHSU);
  assign b_sgn = (op == ALU_MHSS);
  assign ext_a = {{DATA_W{a_sgn & opa[DATA_W-1]}}, opa};
  assign ext_b = {{DATA_W{b_sgn & opb[DATA_W-1]}}, opb};
  assign prod  = ext_a * ext_b;

  always_comb begin
    sh_amt  = opb[SH_W-1:0];
    sh_kind = SH_RLOG;
    case (op)
      ALU_SLL: sh_kind = SH_LEFT;
      ALU_SRA: sh_kind = SH_RARI;
      ALU_ROR: sh_kind = SH_RROT;
      ALU_ROL: begin
        sh_kind = SH_RROT;
        sh_amt  = SH_W'(-opb[SH_W-1:0]);
      end
      default: sh_kind = SH_RLOG;
    endcase
  end

  exu_shifter #(.DATA_W(DATA_W)) u_shift (
    .din  (opa),
    .amt  (sh_amt),
    .kind (sh_kind),
    .dout (sh_out)
  );

  assign lt_s = $signed(opa) < $signed(opb);
  assign lt_u = opa < opb;

  always_comb begin
    case (op)
      ALU_ADD:  res = opa + opb;
      ALU_SUB:  res = opa - opb;
      ALU_MUL:  res = prod[DATA_W-1:0];
      ALU_MHSS, ALU_MHUU, ALU_MHSU: res = prod[PW-1:DATA_W];
      ALU_AND:  res = opa & opb;
      ALU_OR:   res = opa | opb;
      ALU_XOR:  res = opa ^ opb;
      ALU_NOR:  res = ~(opa | opb);
      ALU_SLL, ALU_SRL, ALU_SRA, ALU_ROL, ALU_ROR: res = sh_out;
      ALU_CEQ:  res = DATA_W'(opa == opb);
      ALU_CNE:  res = DATA_W'(opa != opb);
      ALU_CGE:  res = DATA_W'(!lt_s);
      ALU_CLT:  res = DATA_W'(lt_s);
      ALU_CGEU: res = DATA_W'(!lt_u);
      ALU_CLTU: res = DATA_W'(lt_u);
      default:  res = '0;
    endcase
  end

endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
  import exu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int REG_AW = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [31:0]       in_insn,
  output logic [REG_AW-1:0] rf_a_idx,
  output logic [REG_AW-1:0] rf_b_idx,
  input  logic [DATA_W-1:0] rf_a_data,
  input  logic [DATA_W-1:0] rf_b_data,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_result,
  output logic [REG_AW-1:0] out_dest,
  output logic              out_wen,
  output logic              out_illegal
);
  logic [REG_AW-1:0] dec_dest;
  logic              dec_wr;
  logic              dec_ill;
  alu_op_e           dec_op;
  src_b_e            dec_src;
  logic [DATA_W-1:0] dec_imm;
  logic [DATA_W-1:0] opa;
  logic [DATA_W-1:0] regb;
  logic [DATA_W-1:0] opb;
  logic [DATA_W-1:0] alu_res;

  exu_decode #(.DATA_W(DATA_W), .REG_AW(REG_AW)) u_dec (
    .insn    (in_insn),
    .idx_a   (rf_a_idx),
    .idx_b   (rf_b_idx),
    .dest    (dec_dest),
    .dest_wr (dec_wr),
    .illegal (dec_ill),
    .op      (dec_op),
    .src_b   (dec_src),
    .imm_val (dec_imm)
  );

  // register 0 reads as zero
  assign opa  = (rf_a_idx == '0) ? '0 : rf_a_data;
  assign regb = (rf_b_idx == '0) ? '0 : rf_b_data;
  assign opb  = (dec_src == SRC_REG) ? regb : dec_imm;

  exu_alu #(.DATA_W(DATA_W)) u_alu (
    .op  (dec_op),
    .opa (opa),
    .opb (opb),
    .res (alu_res)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_wen     <= 1'b0;
      out_illegal <= 1'b0;
      out_result  <= '0;
      out_dest    <= '0;
    end else begin
      out_valid   <= in_valid;
      out_wen     <= in_valid && dec_wr && (dec_dest != '0);
      out_illegal <= in_valid && dec_ill;
      if (in_valid) begin
        out_result <= alu_res;
        out_dest   <= dec_dest;
      end
    end
  end

  // R9
  r0_write_chk: assert property (@(posedge clk) disable iff (rst)
    out_wen |-> (out_dest != '0));

  // R11
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && !out_wen && !out_illegal));

  // R10
  illegal_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
    out_illegal |-> (!out_wen && out_valid));

  // R12
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && !out_wen && !out_illegal));

endmodule

// File: tb/sim_int_exec_unit.sv
module sim_int_exec_unit;

  function automatic logic [31:0] itype(input logic [5:0] opc, input logic [4:0] a,
                                        input logic [4:0] b, input logic [15:0] imm);
    return {a, b, imm, opc};
  endfunction

  function automatic logic [31:0] rtype(input logic [5:0] opx, input logic [4:0] a,
                                        input logic [4:0] b, input logic [4:0] c,
                                        input logic [4:0] sh);
    return {a, b, c, opx, sh, 6'h3A};
  endfunction

  typedef struct packed {
    logic [31:0] insn;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] res;
    logic [4:0]  dst;
    logic        wen;
    logic        ill;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 47;
  localparam vec_t VEC [NV] = '{
    // R4 register arithmetic and logic
    '{rtype(6'h31,3,4,5,0), 32'h7FFF_FFFF, 32'h1,         32'h8000_0000, 5, 1, 0, 4},
    '{rtype(6'h39,3,4,5,0), 32'h5,         32'h7,         32'hFFFF_FFFE, 5, 1, 0, 4},
    '{rtype(6'h27,3,4,5,0), 32'h0001_0003, 32'h10,        32'h0010_0030, 5, 1, 0, 4},
    '{rtype(6'h0E,3,4,5,0), 32'hF0F0_1234, 32'h0FF0_FF00, 32'h00F0_1200, 5, 1, 0, 4},
    '{rtype(6'h16,3,4,5,0), 32'hF0F0_1234, 32'h0FF0_FF00, 32'hFFF0_FF34, 5, 1, 0, 4},
    '{rtype(6'h1E,3,4,5,0), 32'hF0F0_1234, 32'h0FF0_FF00, 32'hFF00_ED34, 5, 1, 0, 4},
    '{rtype(6'h06,3,4,5,0), 32'hF0F0_1234, 32'h0FF0_FF00, 32'h000F_00CB, 5, 1, 0, 4},
    // R5 register shift amounts masked to 5 bits
    '{rtype(6'h13,3,4,6,0), 32'h3,         32'hFFFF_FFE4, 32'h30,        6, 1, 0, 5},
    '{rtype(6'h1B,3,4,6,0), 32'h8000_0000, 32'h21,        32'h4000_0000, 6, 1, 0, 5},
    '{rtype(6'h3B,3,4,6,0), 32'h8000_0000, 32'h1F,        32'hFFFF_FFFF, 6, 1, 0, 5},
    '{rtype(6'h03,3,4,6,0), 32'h8000_0001, 32'h4,         32'h18,        6, 1, 0, 5},
    '{rtype(6'h0B,3,4,6,0), 32'h8000_0001, 32'h1,         32'hC000_0000, 6, 1, 0, 5},
    '{rtype(6'h0B,3,4,6,0), 32'h1234_5678, 32'h40,        32'h1234_5678, 6, 1, 0, 5},
    // R5 immediate shifts, register B ignored
    '{rtype(6'h12,3,4,7,8),  32'h12,        32'hFFFF,      32'h1200,      7, 1, 0, 5},
    '{rtype(6'h3A,3,4,7,4),  32'h8000_0000, 32'h0,         32'hF800_0000, 7, 1, 0, 5},
    '{rtype(6'h1A,3,4,7,31), 32'h8000_0000, 32'h3,         32'h1,         7, 1, 0, 5},
    '{rtype(6'h02,3,4,7,16), 32'h1234_5678, 32'h9,         32'h5678_1234, 7, 1, 0, 5},
    // R6 register compares
    '{rtype(6'h20,3,4,5,0), 32'h5,         32'h5,         32'h1,         5, 1, 0, 6},
    '{rtype(6'h18,3,4,5,0), 32'h5,         32'h5,         32'h0,         5, 1, 0, 6},
    '{rtype(6'h08,3,4,5,0), 32'hFFFF_FFFF, 32'h1,         32'h0,         5, 1, 0, 6},
    '{rtype(6'h10,3,4,5,0), 32'hFFFF_FFFF, 32'h1,         32'h1,         5, 1, 0, 6},
    '{rtype(6'h28,3,4,5,0), 32'hFFFF_FFFF, 32'h1,         32'h1,         5, 1, 0, 6},
    '{rtype(6'h30,3,4,5,0), 32'hFFFF_FFFF, 32'h1,         32'h0,         5, 1, 0, 6},
    // R7 high multiplies
    '{rtype(6'h1F,3,4,8,0), 32'hFFFF_FFFE, 32'h3,         32'hFFFF_FFFF, 8, 1, 0, 7},
    '{rtype(6'h1F,3,4,8,0), 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0,         8, 1, 0, 7},
    '{rtype(6'h07,3,4,8,0), 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFE, 8, 1, 0, 7},
    '{rtype(6'h17,3,4,8,0), 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 8, 1, 0, 7},
    // R2 immediate extension, I-type writes field B (R1)
    '{itype(6'h04,3,4,16'hFFFF), 32'hA,         32'h55, 32'h9,         4, 1, 0, 2},
    '{itype(6'h0C,3,4,16'h8001), 32'hFFFF_FFFF, 32'h55, 32'h0000_8001, 4, 1, 0, 2},
    '{itype(6'h14,3,4,16'h8000), 32'h1234_0000, 32'h55, 32'h1234_8000, 4, 1, 0, 2},
    '{itype(6'h1C,3,4,16'h00FF), 32'hFFFF_FFFF, 32'h55, 32'hFFFF_FF00, 4, 1, 0, 2},
    '{itype(6'h24,3,9,16'hFFFE), 32'h3,         32'h55, 32'hFFFF_FFFA, 9, 1, 0, 2},
    '{itype(6'h10,3,4,16'hFFFF), 32'hFFFF_FFFE, 32'h55, 32'h1,         4, 1, 0, 2},
    '{itype(6'h30,3,4,16'hFFFF), 32'h0001_0000, 32'h55, 32'h0,         4, 1, 0, 2},
    '{itype(6'h08,3,4,16'h8000), 32'h0,         32'h55, 32'h1,         4, 1, 0, 2},
    '{itype(6'h20,3,4,16'h8000), 32'hFFFF_8000, 32'h55, 32'h1,         4, 1, 0, 2},
    '{itype(6'h18,3,4,16'h0007), 32'h7,         32'h55, 32'h0,         4, 1, 0, 2},
    '{itype(6'h28,3,4,16'hFFFF), 32'hFFFF_0000, 32'h55, 32'h1,         4, 1, 0, 2},
    // R3 upper-half logic forms
    '{itype(6'h2C,3,4,16'hABCD), 32'hFFFF_FFFF, 32'h55, 32'hABCD_0000, 4, 1, 0, 3},
    '{itype(6'h34,3,4,16'h8000), 32'h0000_1111, 32'h55, 32'h8000_1111, 4, 1, 0, 3},
    '{itype(6'h3C,3,4,16'h00FF), 32'hFFFF_FFFF, 32'h55, 32'hFF00_FFFF, 4, 1, 0, 3},
    // R8 register 0 reads as zero
    '{rtype(6'h31,0,4,5,0),      32'hDEAD_BEEF, 32'h5,    32'h5,         5, 1, 0, 8},
    '{rtype(6'h31,3,0,5,0),      32'h77,        32'h1234, 32'h77,        5, 1, 0, 8},
    '{itype(6'h04,0,4,16'h0007), 32'hFFFF_FFFF, 32'h55,   32'h7,         4, 1, 0, 8},
    // R9 writes to register 0 suppressed
    '{rtype(6'h31,3,4,0,0),      32'h1, 32'h2, 32'h0, 0, 0, 0, 9},
    '{itype(6'h04,3,0,16'h0001), 32'h1, 32'h2, 32'h0, 0, 0, 0, 9},
    // R10 unsupported secondary opcode
    '{rtype(6'h25,3,4,5,0),      32'h1, 32'h2, 32'h0, 0, 0, 1, 10}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] in_insn = '0;
  logic [4:0]  rf_a_idx;
  logic [4:0]  rf_b_idx;
  logic [31:0] rf_a_data = '0;
  logic [31:0] rf_b_data = '0;
  logic        out_valid;
  logic [31:0] out_result;
  logic [4:0]  out_dest;
  logic        out_wen;
  logic        out_illegal;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  int_exec_unit u0 (
    .clk, .rst, .in_valid, .in_insn, .rf_a_idx, .rf_b_idx, .rf_a_data, .rf_b_data,
    .out_valid, .out_result, .out_dest, .out_wen, .out_illegal
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 valid in reset", {31'b0, out_valid}, 32'h0);
    chk("R12 wen in reset", {31'b0, out_wen}, 32'h0);
    chk("R12 illegal in reset", {31'b0, out_illegal}, 32'h0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      in_insn   = VEC[i].insn;
      rf_a_data = VEC[i].a;
      rf_b_data = VEC[i].b;
      in_valid  = 1'b1;
      #1;
      // R1 read indices
      chk($sformatf("R1 a index v%0d", i), {27'b0, rf_a_idx}, {27'b0, VEC[i].insn[31:27]});
      chk($sformatf("R1 b index v%0d", i), {27'b0, rf_b_idx}, {27'b0, VEC[i].insn[26:22]});
      @(negedge clk);
      chk($sformatf("R11 valid v%0d req R%0d", i, VEC[i].req), {31'b0, out_valid}, 32'h1);
      chk($sformatf("wen v%0d req R%0d", i, VEC[i].req), {31'b0, out_wen}, {31'b0, VEC[i].wen});
      chk($sformatf("illegal v%0d req R%0d", i, VEC[i].req), {31'b0, out_illegal}, {31'b0, VEC[i].ill});
      if (VEC[i].wen) begin
        chk($sformatf("result v%0d req R%0d", i, VEC[i].req), out_result, VEC[i].res);
        chk($sformatf("R1 dest v%0d", i), {27'b0, out_dest}, {27'b0, VEC[i].dst});
      end
    end

    // R10 more unsupported codes
    in_insn = rtype(6'h00, 3, 4, 5, 0);
    @(negedge clk);
    chk("R10 opx 0x00 illegal", {31'b0, out_illegal}, 32'h1);
    chk("R10 opx 0x00 no write", {31'b0, out_wen}, 32'h0);
    in_insn = rtype(6'h3F, 3, 4, 5, 0);
    @(negedge clk);
    chk("R10 opx 0x3F illegal", {31'b0, out_illegal}, 32'h1);

    // R11 non-execute I-type opcode
    in_insn = itype(6'h17, 3, 4, 16'h0010);
    @(negedge clk);
    chk("R11 other opcode no write", {31'b0, out_wen}, 32'h0);
    chk("R11 other opcode no flag", {31'b0, out_illegal}, 32'h0);
    chk("R11 other opcode valid", {31'b0, out_valid}, 32'h1);

    // R11 idle cycle with a writing instruction on the bus
    in_insn   = rtype(6'h31, 3, 4, 5, 0);
    in_valid  = 1'b0;
    @(negedge clk);
    chk("R11 idle valid", {31'b0, out_valid}, 32'h0);
    chk("R11 idle wen", {31'b0, out_wen}, 32'h0);

    // R12 reset while an instruction is presented
    in_valid = 1'b1;
    rst      = 1'b1;
    @(negedge clk);
    chk("R12 reset overrides valid", {31'b0, out_valid}, 32'h0);
    chk("R12 reset overrides wen", {31'b0, out_wen}, 32'h0);
    rst = 1'b0;
    rf_a_data = 32'h10;
    rf_b_data = 32'h20;
    @(negedge clk);
    chk("R4 after reset result", out_result, 32'h30);
    in_valid = 1'b0;
    @(negedge clk);
    finish_run();
  end

endmodule